// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block derives the I2C serial clock from the core clock with a programmable divider. It also tells the neighbouring data path when to act within each bit. One strobe fires a set number of core clocks after SCL goes low, and marks when the next output bit is to be put on the bus. A second strobe fires a set number of core clocks after SCL goes high, and marks when the incoming bit is to be sampled. A one-cycle tick marks the end of every bit period. Byte framing, start and stop sequencing, data buffering and registers belong to other blocks.

The divider counts core clocks per SCL period. Its lowest bit is ignored, so the period is always even, and it splits into a low half and a high half of equal length. Both delays come in one packed word. Each delay is clamped so that its strobe always falls inside its own half. The generator reads the live SCL level on `scl_in`. While the line is released high but still held low by another device, the high-half count pauses. A new divider or delay word is picked up only when a new SCL period begins.

The controller is a three-state machine:
- `PH_IDLE`: disabled, SCL released high.
- `PH_LOW`: the low half.
- `PH_HIGH`: the high half.

Its transitions are:
- `PH_IDLE` to `PH_LOW` when the enable is seen high; the configuration is loaded here.
- `PH_LOW` to `PH_HIGH` after the last low-half clock.
- `PH_HIGH` to `PH_LOW` after the last counted high-half clock; the configuration is loaded again here.
- Any state to `PH_IDLE` whenever the enable is low.

Top module: `scl_timing_gen`

## Requirements
- R1: Bit 0 of `div_cfg` is ignored. Each SCL half lasts `div_cfg[15:1]` core clocks, so an odd setting behaves like the next lower even one.
- R2: A divider setting of 0 or 1 behaves as the minimum legal value 2, which gives one core clock per half.
- R3: After enabling, SCL (`scl_drive`) is low for the first half of every period and high (released) for the second half.
- R4: The falling-edge delay is `dly_cfg[31:16]`. `drive_stb` pulses once per low half, on low-half clock index min(delay, half-1). Index 0 is the first clock with SCL low.
- R5: The rising-edge delay is `dly_cfg[15:0]`. `sample_stb` pulses once per high half, on counted high-half clock index min(delay, half-1). Index 0 is the first clock with SCL high.
- R6: A delay of 0 fires its strobe on the first core clock of its half, which is the clock on which the edge appears.
- R7: `bit_tick` pulses on the last counted core clock of each high half. SCL is low on the next clock if the block stays enabled.
- R8: While `enable` is low, `scl_drive` is 1 and all three strobes are 0 from the next clock on. Re-enabling starts a fresh period at low-half index 0.
- R9: A divider or delay change made during a period does not affect that period. It applies from the next period onward.
- R10: During the high half, any clock with `scl_in` low (clock stretching) is not counted. On such a clock SCL stays released and neither `sample_stb` nor `bit_tick` fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low forces idle |
| div_cfg | input | 16 | Core clocks per SCL period; bit 0 ignored |
| dly_cfg | input | 32 | [31:16] falling-edge delay, [15:0] rising-edge delay |
| scl_in | input | 1 | Observed SCL line level |
| scl_drive | output | 1 | SCL level to drive: 0 pulls low, 1 releases |
| drive_stb | output | 1 | Put the next data bit out now |
| sample_stb | output | 1 | Sample the incoming data bit now |
| bit_tick | output | 1 | Last clock of the bit period |

## Verification
The bench aims at the divider and delay edges. Odd, zero and maximum divider values are used: a design that honoured bit 0 would stretch one half by a clock, and one that did not floor tiny values would stall with a zero-length half. Delays at, above and far above half the divider are used; a missing clamp would lose the strobe for the whole period. A configuration change in mid-period, an enable drop inside the high half, and a three-clock stretch are also applied. These catch a design that reloads early, that forgets to restart at the low half, or that keeps counting while the line is held low.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/scl_cfg_calc.sv
// Turns raw divider / delay settings into a last-index per half and clamped
// strobe indices. Purely combinational; the phase FSM latches the results.
module scl_cfg_calc #(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16,
    localparam int HALF_W = DIV_W - 1
) (
    input  logic [DIV_W-1:0]   div_cfg,
    input  logic [2*DLY_W-1:0] dly_cfg,
    output logic [HALF_W-1:0]  last_idx,   // half - 1
    output logic [HALF_W-1:0]  fall_idx,   // drive strobe index in low half
    output logic [HALF_W-1:0]  rise_idx    // sample strobe index in high half
);
    logic [HALF_W-1:0] half_raw;
    logic [HALF_W-1:0] half_len;
    logic [HALF_W-1:0] dly_idx [2];

    // R1: bit 0 dropped; R2: a zero half is floored to one clock
    assign half_raw = div_cfg[DIV_W-1:1];
    assign half_len = (half_raw == '0) ? HALF_W'(1) : half_raw;
    assign last_idx = half_len - HALF_W'(1);

    // One clamp per delay field: index 1 = falling-edge field, 0 = rising
    for (genvar g = 0; g < 2; g++) begin : g_clamp
        logic [DLY_W-1:0] raw;
        logic [DLY_W-1:0] lim;
        assign raw = dly_cfg[g*DLY_W +: DLY_W];
        assign lim = DLY_W'(last_idx);
        assign dly_idx[g] = (raw > lim) ? last_idx : HALF_W'(raw);
    end

    assign fall_idx = dly_idx[1];
    assign rise_idx = dly_idx[0];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              scl_in,
    input  logic [HALF_W-1:0] cfg_last,
    input  logic [HALF_W-1:0] cfg_fall,
    input  logic [HALF_W-1:0] cfg_rise,
    output logic              scl_drive,
    output logic              drive_stb,
    output logic              sample_stb,
    output logic              bit_tick
);
    phase_e            st_q, st_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [HALF_W-1:0] last_q, fall_q, rise_q;
    logic              load;

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        load  = 1'b0;
        if (!enable) begin
            st_d  = PH_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PH_IDLE: begin
                    st_d  = PH_LOW;
                    cnt_d = '0;
                    load  = 1'b1;
                end
                PH_LOW: begin
                    if (cnt_q == last_q) begin
                        st_d  = PH_HIGH;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + HALF_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (scl_in) begin
                        if (cnt_q == last_q) begin
                            st_d  = PH_LOW;
                            cnt_d = '0;
                            load  = 1'b1;
                        end else begin
                            cnt_d = cnt_q + HALF_W'(1);
                        end
                    end
                end
                default: begin
                    st_d  = PH_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            last_q <= '0;
            fall_q <= '0;
            rise_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (load) begin
                last_q <= cfg_last;
                fall_q <= cfg_fall;
                rise_q <= cfg_rise;
            end
        end
    end

    // Outputs
    always_comb begin
        scl_drive  = (st_q != PH_LOW);
        drive_stb  = (st_q == PH_LOW) && (cnt_q == fall_q);
        sample_stb = (st_q == PH_HIGH) && scl_in && (cnt_q == rise_q);
        bit_tick   = (st_q == PH_HIGH) && scl_in && (cnt_q == last_q);
    end

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_drive && !drive_stb && !sample_stb && !bit_tick));

    // R4
    drive_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> !scl_drive);

    // R5
    sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (scl_drive && scl_in && !drive_stb));

    // R7
    tick_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && enable) |=> !scl_drive);

    // R10
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_HIGH && !scl_in && enable) |=> (st_q == PH_HIGH && $stable(cnt_q)));

    // R9
    reload_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(last_q) && $stable(fall_q) && $stable(rise_q)) |-> (st_q == PH_LOW && cnt_q == '0));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16,
    localparam int HALF_W = DIV_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   div_cfg,
    input  logic [2*DLY_W-1:0] dly_cfg,
    input  logic               scl_in,
    output logic               scl_drive,
    output logic               drive_stb,
    output logic               sample_stb,
    output logic               bit_tick
);
    logic [HALF_W-1:0] c_last, c_fall, c_rise;

    scl_cfg_calc #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_cfg (
        .div_cfg (div_cfg),
        .dly_cfg (dly_cfg),
        .last_idx(c_last),
        .fall_idx(c_fall),
        .rise_idx(c_rise)
    );

    scl_phase_fsm #(.HALF_W(HALF_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .scl_in    (scl_in),
        .cfg_last  (c_last),
        .cfg_fall  (c_fall),
        .cfg_rise  (c_rise),
        .scl_drive (scl_drive),
        .drive_stb (drive_stb),
        .sample_stb(sample_stb),
        .bit_tick  (bit_tick)
    );
endmodule

// File: tb/scl_timing_gen_tb.sv
`timescale 1ns/1ps
module scl_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] div_cfg = 16'd8;
    logic [31:0] dly_cfg = 32'd0;
    logic        hold_low = 1'b0;
    logic        scl_in;
    logic        scl_drive, drive_stb, sample_stb, bit_tick;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    // wired-AND line: another device may hold SCL low
    assign scl_in = scl_drive & ~hold_low;

    scl_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_cfg(div_cfg),
        .dly_cfg(dly_cfg), .scl_in(scl_in), .scl_drive(scl_drive),
        .drive_stb(drive_stb), .sample_stb(sample_stb), .bit_tick(bit_tick)
    );

    // {div, fall dly, rise dly, expected half, expected drive idx, expected sample idx}
    localparam logic [95:0] VEC [8] = '{
        {16'd8,      16'd1,      16'd2, 16'd4,      16'd1,      16'd2},  // R1 R3 R4 R5
        {16'd9,      16'd0,      16'd0, 16'd4,      16'd0,      16'd0},  // R1 odd, R6
        {16'd6,      16'd10,     16'd7, 16'd3,      16'd2,      16'd2},  // clamp R4 R5
        {16'd1,      16'd0,      16'd0, 16'd1,      16'd0,      16'd0},  // R2
        {16'd2,      16'd1,      16'd1, 16'd1,      16'd0,      16'd0},  // min legal, clamp
        {16'd20,     16'd3,      16'd9, 16'd10,     16'd3,      16'd9},
        {16'hFFFF,   16'hFFFF,   16'd0, 16'h7FFF,   16'h7FFE,   16'd0},  // max, R1
        {16'd0,      16'd5,      16'd0, 16'd1,      16'd0,      16'd0}   // R2 zero
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int idx);
        logic [95:0] v;
        int h, d, s, bad_scl, bad_drv, bad_smp, bad_tck, first;
        v = VEC[idx];
        h = int'(v[47:32]);
        d = int'(v[31:16]);
        s = int'(v[15:0]);
        bad_scl = 0; bad_drv = 0; bad_smp = 0; bad_tck = 0; first = -1;
        @(negedge clk);
        div_cfg = v[95:80];
        dly_cfg = {v[79:64], v[63:48]};
        enable = 1'b1;
        for (int k = 0; k <= 2*h; k++) begin
            int kk;
            @(negedge clk);
            kk = k % (2*h);
            if (scl_drive !== (kk >= h)) begin bad_scl++; if (first < 0) first = k; end
            if (drive_stb !== (kk == d)) bad_drv++;
            if (sample_stb !== (kk == h + s)) bad_smp++;
            if (bit_tick !== (kk == 2*h - 1)) bad_tck++;
        end
        chk(bad_scl == 0, $sformatf("R1/R2/R3 vec%0d scl mismatches (first k=%0d)", idx, first), bad_scl, 0);
        chk(bad_drv == 0, $sformatf("R4/R6 vec%0d drive_stb mismatches", idx), bad_drv, 0);
        chk(bad_smp == 0, $sformatf("R5/R6 vec%0d sample_stb mismatches", idx), bad_smp, 0);
        chk(bad_tck == 0, $sformatf("R7 vec%0d bit_tick mismatches", idx), bad_tck, 0);
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        // reset state
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl_drive === 1'b1, "R8 reset scl_drive", scl_drive, 1);
        chk({drive_stb, sample_stb, bit_tick} === 3'b000, "R8 reset strobes",
            {drive_stb, sample_stb, bit_tick}, 0);
        enable = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 8; i++) run_vec(i);

        // R9: change config during the first period
        div_cfg = 16'd8; dly_cfg = {16'd1, 16'd2}; enable = 1'b1;
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (k == 0) begin
                    div_cfg = 16'd4;
                    dly_cfg = 32'd0;
                end
                // old: half 4 d1 s2 for k 0..7; new: half 2 d0 s0 for k 8..11
                if (scl_drive !== ((k >= 4 && k < 8) || k >= 10)) bad++;
                if (drive_stb !== (k == 1 || k == 8)) bad++;
                if (sample_stb !== (k == 6 || k == 10)) bad++;
            end
            chk(bad == 0, "R9 mid-period config change", bad, 0);
        end
        enable = 1'b0;
        @(negedge clk);

        // R8: drop enable inside the high half, then restart
        div_cfg = 16'd8; dly_cfg = {16'd0, 16'd2}; enable = 1'b1;
        repeat (5) @(negedge clk);  // k=0..4, k=4 is high half
        chk(scl_drive === 1'b1, "R3 high half before disable", scl_drive, 1);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_drive === 1'b1 && {drive_stb, sample_stb, bit_tick} === 3'b000,
            "R8 disabled outputs", {scl_drive, drive_stb, sample_stb, bit_tick}, 8);
        repeat (2) @(negedge clk);
        chk(scl_drive === 1'b1 && {drive_stb, sample_stb, bit_tick} === 3'b000,
            "R8 disabled outputs held", {scl_drive, drive_stb, sample_stb, bit_tick}, 8);
        enable = 1'b1;
        @(negedge clk);
        chk(scl_drive === 1'b0 && drive_stb === 1'b1, "R8 R6 restart at low index 0",
            {scl_drive, drive_stb}, 1);
        enable = 1'b0;
        @(negedge clk);

        // R10: stretch three clocks at the start of the high half
        div_cfg = 16'd8; dly_cfg = {16'd1, 16'd2}; enable = 1'b1;
        repeat (5) @(negedge clk);  // k=4: first high clock, count 0
        hold_low = 1'b1;
        begin
            int bad;
            bad = 0;
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                if (scl_drive !== 1'b1 || sample_stb !== 1'b0 || bit_tick !== 1'b0) bad++;
            end
            chk(bad == 0, "R10 stretched clocks frozen", bad, 0);
        end
        hold_low = 1'b0;
        @(negedge clk);  // count 1
        @(negedge clk);  // count 2
        chk(sample_stb === 1'b1, "R10 R5 sample after stretch", sample_stb, 1);
        @(negedge clk);
        chk(bit_tick === 1'b1 && scl_drive === 1'b1, "R10 R7 tick after stretch",
            {bit_tick, scl_drive}, 3);
        @(negedge clk);
        chk(scl_drive === 1'b0, "R7 low half after tick", scl_drive, 0);
        enable = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule